// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Slave

This block is the receive front end of an audio-control device on a two-wire serial bus. It accepts only writes. Both bus lines are brought into the system clock through synchronizers. The block then finds start and stop conditions and shifts in bytes MSB first. The first byte after a start is compared against a 7-bit device address. One bit of that address is taken from an external strap pin, and the eighth bit (direction) must be 0.

On a match the block pulls SDA low for the ninth clock of the address byte and of every data byte that follows. Any number of data bytes may follow one address. Each data byte goes to a downstream register decoder as a byte value with a one-cycle valid strobe, after its ninth clock has ended. A transfer with a wrong address or with the direction bit set is ignored until the next start. During such a transfer SDA is never driven.

Top module: `twb_write_slave`

## Requirements
- R1: After reset, `sda_pull_o` and `data_valid_o` are 0. Bytes clocked without a preceding start condition (SDA falling while SCL is high) get no acknowledge and produce no strobe.
- R2: After a start, the address byte 1,0,0,0,1,0,A,0 (MSB first) is acknowledged when A equals `addr_sel_i`.
- R3: The strap bit is address bit 1 of the byte (the bit just before the direction bit). With `addr_sel_i`=1, byte 0x8A is acknowledged and 0x88 is not.
- R4: An address byte whose last bit (direction) is 1 is not acknowledged. Nothing is driven or strobed for the rest of that transfer.
- R5: After a non-matching address, the following bytes get no acknowledge and no strobe until the next start.
- R6: For each accepted byte, `sda_pull_o` is high throughout the SCL-high phase of the ninth clock. It is low again after the SCL falling edge that ends the ninth clock.
- R7: `sda_pull_o` is never high while SCL is high during data bits 1 to 8 of any byte.
- R8: Each acknowledged data byte gives exactly one single-cycle `data_valid_o` pulse after the ninth clock's falling edge. `data_o` carries the byte, first received bit in bit 7. Consecutive bytes after one address are all delivered in order.
- R9: A start that arrives in the middle of a transfer restarts address matching. A matching address then reopens the transfer, and a non-matching one closes it.
- R10: A stop condition (SDA rising while SCL is high) in the middle of a byte discards the partial byte without a strobe. A later start with a matching address is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Strap pin giving one bit of the device address |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| data_o | output | 8 | Last accepted data byte |
| data_valid_o | output | 1 | One-cycle strobe marking a new `data_o` |

## Verification
The assertions run on every cycle and cover the following. The acknowledge may rise only on the SCL falling edge that ends the eighth bit. It holds steady while SCL stays high. It is never on in the ignore state. The valid strobe is always a single cycle that follows an SCL falling edge. Whether the address pattern, the strap bit and the direction bit are decoded correctly is shown only by the bench scenarios. The same holds for bytes arriving MSB first with their values intact, repeated starts restarting matching, and a stop discarding half a byte. The bench drives whole transfers through an open-drain bus model for these.

// File: rtl/twb_pkg.sv
package twb_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_ACK,
      ST_SKIP
   } twb_state_e;
endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("twb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = lvl_o & ~prev_q;
   assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/twb_addr_match.sv
module twb_addr_match #(
   parameter logic [twb_pkg::ADDR_W-1:0] DEV_ADDR  = 7'b1000100,
   parameter int                         STRAP_POS = 0
) (
   input  logic [twb_pkg::BYTE_W-1:0] byte_i,
   input  logic                       strap_i,
   output logic                       hit_o
);
   import twb_pkg::*;

   if (STRAP_POS < 0 || STRAP_POS >= ADDR_W) begin : g_bad_pos
      $error("twb_addr_match: STRAP_POS out of range");
   end

   logic [ADDR_W-1:0] expect_addr;

   always_comb begin
      expect_addr            = DEV_ADDR;
      expect_addr[STRAP_POS] = strap_i;
   end

   // upper seven bits carry the address, bit 0 is the direction (0 = write)
   assign hit_o = (byte_i[BYTE_W-1:1] == expect_addr) && !byte_i[0];
endmodule

// File: rtl/twb_engine.sv
module twb_engine (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_lvl,
   input  logic                       scl_rise,
   input  logic                       scl_fall,
   input  logic                       sda_lvl,
   input  logic                       sda_rise,
   input  logic                       sda_fall,
   input  logic                       addr_hit,
   output logic [twb_pkg::BYTE_W-1:0] shift_o,
   output logic                       pull_o,
   output logic [twb_pkg::BYTE_W-1:0] data_o,
   output logic                       valid_o
);
   import twb_pkg::*;

   localparam int             CW       = $clog2(BYTE_W + 1);
   localparam logic [CW-1:0]  LAST_BIT = CW'(BYTE_W);

   twb_state_e         state_q;
   logic [CW-1:0]      cnt_q;
   logic [BYTE_W-1:0]  shift_q;
   logic [BYTE_W-1:0]  data_q;
   logic               pull_q;
   logic               ack_data_q;
   logic               valid_q;

   logic start_det, stop_det;
   assign start_det = sda_fall & scl_lvl;
   assign stop_det  = sda_rise & scl_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         shift_q    <= '0;
         data_q     <= '0;
         pull_q     <= 1'b0;
         ack_data_q <= 1'b0;
         valid_q    <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (start_det) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
         end else if (stop_det) begin
            state_q <= ST_IDLE;
            pull_q  <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR, ST_DATA: begin
                  if (scl_rise && cnt_q != LAST_BIT) begin
                     shift_q <= {shift_q[BYTE_W-2:0], sda_lvl};
                     cnt_q   <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == LAST_BIT) begin
                     if (state_q == ST_DATA) begin
                        pull_q     <= 1'b1;
                        ack_data_q <= 1'b1;
                        data_q     <= shift_q;
                        state_q    <= ST_ACK;
                     end else if (addr_hit) begin
                        pull_q     <= 1'b1;
                        ack_data_q <= 1'b0;
                        state_q    <= ST_ACK;
                     end else begin
                        state_q    <= ST_SKIP;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     pull_q  <= 1'b0;
                     cnt_q   <= '0;
                     state_q <= ST_DATA;
                     valid_q <= ack_data_q;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign shift_o = shift_q;
   assign pull_o  = pull_q;
   assign data_o  = data_q;
   assign valid_o = valid_q;

   // R6: acknowledge switches on only at the fall that closes the eighth bit
   a_r6_ack_on_eighth_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_q) |-> ($past(scl_fall) && $past(cnt_q) == LAST_BIT));
   // R6: acknowledge level holds while SCL stays high
   a_r6_ack_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
      |-> $stable(pull_q));
   // R5: nothing driven while ignoring a transfer
   a_r5_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |-> !pull_q);
   // R8: strobe lasts one cycle and follows an SCL fall
   a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);
   a_r8_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> $past(scl_fall));
endmodule

// File: rtl/twb_write_slave.sv
module twb_write_slave #(
   parameter int                         SYNC_STAGES = 2,
   parameter logic [twb_pkg::ADDR_W-1:0] DEV_ADDR    = 7'b1000100,
   parameter int                         STRAP_POS   = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       addr_sel_i,
   output logic       sda_pull_o,
   output logic [7:0] data_o,
   output logic       data_valid_o
);
   import twb_pkg::*;

   localparam int LANES = 2;  // lane 0 = SCL, lane 1 = SDA

   logic [LANES-1:0] raw_v, lvl_v, rise_v, fall_v;
   assign raw_v = {sda_i, scl_i};

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      twb_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .d_i    (raw_v[g]),
         .lvl_o  (lvl_v[g]),
         .rise_o (rise_v[g]),
         .fall_o (fall_v[g])
      );
   end

   logic [BYTE_W-1:0] shift_w;
   logic              hit_w;

   twb_addr_match #(.DEV_ADDR(DEV_ADDR), .STRAP_POS(STRAP_POS)) u_match (
      .byte_i  (shift_w),
      .strap_i (addr_sel_i),
      .hit_o   (hit_w)
   );

   twb_engine u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_lvl  (lvl_v[0]),
      .scl_rise (rise_v[0]),
      .scl_fall (fall_v[0]),
      .sda_lvl  (lvl_v[1]),
      .sda_rise (rise_v[1]),
      .sda_fall (fall_v[1]),
      .addr_hit (hit_w),
      .shift_o  (shift_w),
      .pull_o   (sda_pull_o),
      .data_o   (data_o),
      .valid_o  (data_valid_o)
   );
endmodule

// File: tb/twb_write_slave_bench.sv
module twb_write_slave_bench;
   localparam int Q = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic addr_sel = 1'b0;
   logic sda_pull;
   logic [7:0] data;
   logic data_valid;
   logic sda_line;

   int tests = 0;
   int fails = 0;
   int vcnt = 0;
   int doubles = 0;
   int pull_cycles = 0;
   logic [7:0] got [64];
   logic prev_valid = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull;

   twb_write_slave u_twb_write_slave (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_line),
      .addr_sel_i   (addr_sel),
      .sda_pull_o   (sda_pull),
      .data_o       (data),
      .data_valid_o (data_valid)
   );

   always @(negedge clk) begin
      if (data_valid) begin
         got[vcnt % 64] = data;
         vcnt++;
      end
      if (data_valid && prev_valid) doubles++;
      if (sda_pull) pull_cycles++;
      prev_valid = data_valid;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_q(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wait_q(Q);
      scl_m = 1'b1; wait_q(Q);
      sda_m = 1'b0; wait_q(Q);
      scl_m = 1'b0; wait_q(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wait_q(Q);
      scl_m = 1'b1; wait_q(Q);
      sda_m = 1'b1; wait_q(Q);
   endtask

   task automatic bus_bits(input logic [7:0] b, input int n, output bit pulled);
      pulled = 1'b0;
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; wait_q(Q);
         scl_m = 1'b1; wait_q(Q / 2);
         if (sda_pull) pulled = 1'b1;
         wait_q(Q / 2);
         scl_m = 1'b0;
      end
   endtask

   // sends a byte, checks R7 on bits 1..8 and R6 on the ninth clock
   task automatic bus_byte(input logic [7:0] b, input bit exp_ack, input string req);
      bit pulled;
      bit acked;
      bus_bits(b, 8, pulled);
      chk(!pulled, "R7 no pull in data bits", pulled, 0);
      sda_m = 1'b1; wait_q(Q);
      scl_m = 1'b1; wait_q(2);
      acked = !sda_line;
      wait_q(Q - 4);
      if (!sda_line != acked) acked = 1'b0;
      wait_q(2);
      scl_m = 1'b0;
      chk(acked == exp_ack, req, acked, exp_ack);
      wait_q(Q);
      chk(!sda_pull, "R6 released after ninth clock", sda_pull, 0);
   endtask

   task automatic t_reset;
      chk(!sda_pull, "R1 reset pull", sda_pull, 0);
      chk(!data_valid, "R1 reset valid", data_valid, 0);
   endtask

   task automatic t_no_start;
      int v0 = vcnt;
      int p0 = pull_cycles;
      bus_bits(8'h00, 0, done);
      scl_m = 1'b0; wait_q(Q);
      bus_byte(8'h88, 1'b0, "R1 no ack without start");
      bus_byte(8'h12, 1'b0, "R1 no ack without start data");
      bus_stop;
      chk(vcnt == v0, "R1 no strobe without start", vcnt, v0);
      chk(pull_cycles == p0, "R1 never driven", pull_cycles, p0);
   endtask

   task automatic t_basic;
      int v0 = vcnt;
      addr_sel = 1'b0;
      bus_start;
      bus_byte(8'h88, 1'b1, "R2 address ack");
      bus_byte(8'hA5, 1'b1, "R6 data ack 1");
      bus_byte(8'h3C, 1'b1, "R6 data ack 2");
      bus_byte(8'hF0, 1'b1, "R6 data ack 3");
      bus_stop;
      chk(vcnt == v0 + 3, "R8 strobe count", vcnt - v0, 3);
      chk(got[v0 % 64] == 8'hA5, "R8 byte 1 MSB first", got[v0 % 64], 8'hA5);
      chk(got[(v0 + 1) % 64] == 8'h3C, "R8 byte 2", got[(v0 + 1) % 64], 8'h3C);
      chk(got[(v0 + 2) % 64] == 8'hF0, "R8 byte 3", got[(v0 + 2) % 64], 8'hF0);
      chk(doubles == 0, "R8 single-cycle strobe", doubles, 0);
   endtask

   task automatic t_strap;
      int v0;
      addr_sel = 1'b1;
      v0 = vcnt;
      bus_start;
      bus_byte(8'h8A, 1'b1, "R3 strap=1 address ack");
      bus_byte(8'h11, 1'b1, "R3 data ack");
      bus_stop;
      chk(vcnt == v0 + 1 && got[v0 % 64] == 8'h11, "R3 data delivered", got[v0 % 64], 8'h11);
      v0 = vcnt;
      bus_start;
      bus_byte(8'h88, 1'b0, "R3 strap=1 rejects A=0");
      bus_byte(8'h22, 1'b0, "R5 follow-up byte ignored");
      bus_stop;
      chk(vcnt == v0, "R5 no strobe after mismatch", vcnt, v0);
      addr_sel = 1'b0;
   endtask

   task automatic t_read_dir;
      int v0 = vcnt;
      int p0 = pull_cycles;
      bus_start;
      bus_byte(8'h89, 1'b0, "R4 direction bit rejects");
      bus_byte(8'h55, 1'b0, "R4 later byte not acked");
      bus_stop;
      chk(vcnt == v0, "R4 no strobe", vcnt, v0);
      chk(pull_cycles == p0, "R4 SDA never driven", pull_cycles, p0);
   endtask

   task automatic t_restart;
      int v0 = vcnt;
      bus_start;
      bus_byte(8'h88, 1'b1, "R9 first address ack");
      bus_byte(8'h77, 1'b1, "R9 first data ack");
      bus_start;
      bus_byte(8'h8A, 1'b0, "R9 restart with wrong address");
      bus_byte(8'h66, 1'b0, "R9 closed transfer ignored");
      bus_start;
      bus_byte(8'h88, 1'b1, "R9 restart reopens");
      bus_byte(8'h99, 1'b1, "R9 reopened data ack");
      bus_stop;
      chk(vcnt == v0 + 2, "R9 strobe count", vcnt - v0, 2);
      chk(got[v0 % 64] == 8'h77 && got[(v0 + 1) % 64] == 8'h99, "R9 bytes",
          got[(v0 + 1) % 64], 8'h99);
   endtask

   task automatic t_abort;
      int v0 = vcnt;
      bit pulled;
      bus_start;
      bus_byte(8'h88, 1'b1, "R10 address ack");
      bus_bits(8'hC3, 4, pulled);
      bus_stop;
      wait_q(Q);
      chk(vcnt == v0 && !pulled, "R10 partial byte dropped", vcnt, v0);
      bus_start;
      bus_byte(8'h88, 1'b1, "R10 recovery address ack");
      bus_byte(8'h42, 1'b1, "R10 recovery data ack");
      bus_stop;
      chk(vcnt == v0 + 1 && got[v0 % 64] == 8'h42, "R10 recovery byte", got[v0 % 64], 8'h42);
   endtask

   initial begin
      wait_q(5);
      t_reset;
      rst_n = 1'b1;
      wait_q(5);
      t_reset;
      t_no_start;
      t_basic;
      t_strap;
      t_read_dir;
      t_restart;
      t_abort;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule